// File: doc/BRIEF.md
# Programmable Divider and Phase-Frequency Detector

This block is the digital heart of a frequency synthesizer. A VCO-derived tick stream is divided by a programmable 15-bit ratio. A crystal-derived tick stream is divided by a fixed 64 to form the comparison reference. A phase-frequency detector compares the falling edges of the two divided square waves. It produces pump-up and pump-down requests plus a high-impedance enable for an external charge pump. The loop filter, the pump itself and the VCO are not part of the block.

All logic runs on one fast system clock. The VCO and crystal are presented as single-cycle tick strobes, so every edge is seen at system-clock resolution. The block also has a two-bit test mode. The modes turn the pump off, bring both divided signals out on two port pins, or drive the detector from two external pins that are resynchronised to the system clock. A separate select bit chooses between a high and a low pump current and is passed straight out.

Top module: `pll_div_pfd`

## Requirements
- R1: With ratio N written (256 ≤ N ≤ 32767, plain binary), the divided VCO signal has a period of exactly N VCO ticks, and its falling edge occurs on the tick that wraps the divider.
- R2: A written ratio below 256 is used as 256.
- R3: A ratio write does not cut short the period in progress. The new ratio takes effect from the next wrap of the divider.
- R4: The reference signal has a period of exactly 64 crystal ticks.
- R5: When the divided VCO signal falls before the reference, `up_o` stays high for exactly the number of system-clock cycles between the two falling edges, and `dn_o` stays low.
- R6: When the reference falls first, `dn_o` stays high for exactly the number of cycles between the edges, and `up_o` stays low.
- R7: Falling edges that arrive in the same cycle give no pulse. `up_o` and `dn_o` are never high together.
- R8: Mode {t1_i,t0_i} = 01 holds `up_o` and `dn_o` low and `pump_hiz_o` high, whatever the detector inputs do.
- R9: In every other mode, `pump_hiz_o` is high exactly when neither `up_o` nor `dn_o` is high.
- R10: In mode 10, `port1_o` carries the divided VCO signal, `port0_o` carries the reference and `test_drive_o` is 1. In all other modes these three outputs are 0.
- R11: In mode 11, the detector takes `ext_vco_i` in place of the divided VCO and `ext_ref_i` in place of the reference. The internal dividers then have no effect on the detector.
- R12: `pump_hi_o` follows `cur_sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vco_tick_i | input | 1 | One-cycle strobe per VCO period |
| xtal_tick_i | input | 1 | One-cycle strobe per crystal period |
| ratio_i | input | 15 | Programmable divide ratio |
| ratio_wr_i | input | 1 | Strobe that captures ratio_i |
| t1_i | input | 1 | Test mode, upper bit |
| t0_i | input | 1 | Test mode, lower bit |
| cur_sel_i | input | 1 | Pump current select (1 = high) |
| ext_vco_i | input | 1 | External VCO-side detector input (mode 11) |
| ext_ref_i | input | 1 | External reference-side detector input (mode 11) |
| up_o | output | 1 | Pump-up request |
| dn_o | output | 1 | Pump-down request |
| pump_hiz_o | output | 1 | Pump output in high impedance |
| pump_hi_o | output | 1 | High pump current selected |
| port1_o | output | 1 | Divided VCO signal in mode 10 |
| port0_o | output | 1 | Reference signal in mode 10 |
| test_drive_o | output | 1 | Test ports are being driven |

## Verification
The detector is driven through the external pins with a VCO-first lead, a reference-first lead and coincident edges. These three patterns separate the up path, the down path and the simultaneous-clear path, and each pulse width is compared with the lead in cycles. In closed-loop patterns, a VCO faster than the reference must produce only up pulses and a slower one only down pulses. The same stimulus in pump-off mode must produce none. Divider periods are measured at the test port for the minimum, a mid value, an odd value and the maximum ratio, for values below the minimum, and across a write made mid-period, which exposes a premature reload.

// File: rtl/pll_div_pfd_pkg.sv
package pll_div_pfd_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'b00,
    MODE_PUMP_OFF = 2'b01,
    MODE_DIV_OUT  = 2'b10,
    MODE_EXT_IN   = 2'b11
  } test_mode_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tick_div.sv
module tick_div #(
  parameter int CW          = 15,
  parameter int NMIN        = 256,
  parameter int RESET_RATIO = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [CW-1:0] ratio_i,
  input  logic          ratio_wr_i,
  output logic          div_o
);
  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [CW-1:0] MIN_R = CW'(NMIN);
  localparam logic [CW-1:0] RST_R = CW'(RESET_RATIO);

  logic [CW-1:0] cnt_q, act_q, pend_q;
  logic [CW-1:0] cnt_n, act_n;
  logic          wrap;
  logic          div_q;

  function automatic logic [CW-1:0] floor_ratio(input logic [CW-1:0] r);
    return (r < MIN_R) ? MIN_R : r;
  endfunction

  assign wrap = tick_i && (cnt_q == act_q - ONE);

  always_comb begin
    cnt_n = cnt_q;
    act_n = act_q;
    if (tick_i) begin
      if (wrap) begin
        cnt_n = '0;
        act_n = floor_ratio(pend_q);  // reload only at wrap: no runt period
      end else begin
        cnt_n = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      act_q  <= RST_R;
      pend_q <= RST_R;
      div_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      act_q <= act_n;
      if (ratio_wr_i) pend_q <= ratio_i;
      div_q <= (cnt_n >= (act_n >> 1));  // low half starts at wrap
    end
  end

  assign div_o = div_q;

  p_cnt_below_ratio_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < act_q);
  p_ratio_floor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q >= MIN_R);
  p_reload_at_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(act_q));
  p_fall_at_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && div_q) |=> !div_q);
endmodule

// File: rtl/edge_pfd.sv
module edge_pfd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic vco_i,
  output logic up_o,
  output logic dn_o
);
  logic ref_q, vco_q;
  logic up_q, dn_q;
  logic ref_fall, vco_fall;
  logic up_set, dn_set;

  assign ref_fall = ref_q & ~ref_i;
  assign vco_fall = vco_q & ~vco_i;
  assign up_set   = up_q | vco_fall;
  assign dn_set   = dn_q | ref_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 1'b0;
      vco_q <= 1'b0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      ref_q <= ref_i;
      vco_q <= vco_i;
      // both latched: clear both in the same cycle
      if (up_set && dn_set) begin
        up_q <= 1'b0;
        dn_q <= 1'b0;
      end else begin
        up_q <= up_set;
        dn_q <= dn_set;
      end
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;

  p_never_both_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_q && dn_q));
  p_up_starts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vco_fall && !ref_fall && !dn_q) |=> up_q);
  p_dn_starts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_fall && !vco_fall && !up_q) |=> dn_q);
  p_coincident_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_fall && vco_fall && !up_q && !dn_q) |=> (!up_q && !dn_q));
endmodule

// File: rtl/pll_div_pfd.sv
module pll_div_pfd
  import pll_div_pfd_pkg::*;
#(
  parameter int NW          = 15,
  parameter int NMIN        = 256,
  parameter int REF_RATIO   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vco_tick_i,
  input  logic          xtal_tick_i,
  input  logic [NW-1:0] ratio_i,
  input  logic          ratio_wr_i,
  input  logic          t1_i,
  input  logic          t0_i,
  input  logic          cur_sel_i,
  input  logic          ext_vco_i,
  input  logic          ext_ref_i,
  output logic          up_o,
  output logic          dn_o,
  output logic          pump_hiz_o,
  output logic          pump_hi_o,
  output logic          port1_o,
  output logic          port0_o,
  output logic          test_drive_o
);
  localparam int RW = $clog2(REF_RATIO + 1);

  test_mode_e mode;
  logic       vco_div, ref_div;
  logic [1:0] ext_s;
  logic       pfd_vco, pfd_ref;
  logic       up_raw, dn_raw;
  logic       pump_off;

  assign mode     = test_mode_e'({t1_i, t0_i});
  assign pump_off = (mode == MODE_PUMP_OFF);

  tick_div #(.CW(NW), .NMIN(NMIN), .RESET_RATIO(NMIN)) u_vco_div (
    .clk_i, .rst_ni,
    .tick_i     (vco_tick_i),
    .ratio_i    (ratio_i),
    .ratio_wr_i (ratio_wr_i),
    .div_o      (vco_div)
  );

  tick_div #(.CW(RW), .NMIN(REF_RATIO), .RESET_RATIO(REF_RATIO)) u_ref_div (
    .clk_i, .rst_ni,
    .tick_i     (xtal_tick_i),
    .ratio_i    (RW'(REF_RATIO)),
    .ratio_wr_i (1'b0),
    .div_o      (ref_div)
  );

  pin_sync #(.W(2), .STAGES(SYNC_STAGES)) u_ext_sync (
    .clk_i, .rst_ni,
    .d_i ({ext_vco_i, ext_ref_i}),
    .q_o (ext_s)
  );

  always_comb begin
    if (mode == MODE_EXT_IN) begin
      pfd_vco = ext_s[1];
      pfd_ref = ext_s[0];
    end else begin
      pfd_vco = vco_div;
      pfd_ref = ref_div;
    end
  end

  edge_pfd u_pfd (
    .clk_i, .rst_ni,
    .ref_i (pfd_ref),
    .vco_i (pfd_vco),
    .up_o  (up_raw),
    .dn_o  (dn_raw)
  );

  assign up_o         = up_raw & ~pump_off;
  assign dn_o         = dn_raw & ~pump_off;
  assign pump_hiz_o   = pump_off | ~(up_raw | dn_raw);
  assign pump_hi_o    = cur_sel_i;
  assign test_drive_o = (mode == MODE_DIV_OUT);
  assign port1_o      = test_drive_o & vco_div;
  assign port0_o      = test_drive_o & ref_div;

  p_pump_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pump_off |-> (pump_hiz_o && !up_o && !dn_o));
  p_hiz_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pump_off |-> (pump_hiz_o == !(up_o || dn_o)));
  p_ports_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != MODE_DIV_OUT) |-> (!port0_o && !port1_o && !test_drive_o));
  p_cur_follow_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pump_hi_o == cur_sel_i);
endmodule

// File: tb/pll_div_pfd_tb.sv
module pll_div_pfd_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        vco_tick = 1'b0, xtal_tick = 1'b0;
  logic [14:0] ratio = 15'd256;
  logic        ratio_wr = 1'b0;
  logic        t1 = 1'b0, t0 = 1'b0;
  logic        cur_sel = 1'b0;
  logic        ext_vco = 1'b1, ext_ref = 1'b1;
  logic        up, dn, hiz, phi, p1, p0, tdrv;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pll_div_pfd u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .vco_tick_i(vco_tick), .xtal_tick_i(xtal_tick),
    .ratio_i(ratio), .ratio_wr_i(ratio_wr), .t1_i(t1), .t0_i(t0),
    .cur_sel_i(cur_sel), .ext_vco_i(ext_vco), .ext_ref_i(ext_ref),
    .up_o(up), .dn_o(dn), .pump_hiz_o(hiz), .pump_hi_o(phi),
    .port1_o(p1), .port0_o(p0), .test_drive_o(tdrv)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_ratio(input int v);
    @(negedge clk) begin ratio = 15'(v); ratio_wr = 1'b1; end
    @(negedge clk) ratio_wr = 1'b0;
  endtask

  // cycles until next falling edge of port1 (sel=1) or port0 (sel=0)
  task automatic wait_fall(input bit sel, output int n);
    logic p;
    n = 0;
    p = sel ? p1 : p0;
    while (n < 40000) begin
      @(negedge clk);
      n++;
      if (p && !(sel ? p1 : p0)) break;
      p = sel ? p1 : p0;
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(up == 1'b0, "R5 reset up", up, 0);
    chk(dn == 1'b0, "R6 reset dn", dn, 0);
    chk(hiz == 1'b1, "R9 reset hiz", hiz, 1);
    chk(tdrv == 1'b0, "R10 reset test_drive", tdrv, 0);
    chk(p1 == 1'b0 && p0 == 1'b0, "R10 reset ports", {p1, p0}, 0);
  endtask

  task automatic t_cur_sel();
    @(negedge clk) cur_sel = 1'b1;
    @(negedge clk) chk(phi == 1'b1, "R12 high current", phi, 1);
    cur_sel = 1'b0;
    @(negedge clk) chk(phi == 1'b0, "R12 low current", phi, 0);
  endtask

  task automatic t_div_period(input int wr, input int exp, input string req);
    int n;
    t1 = 1'b1; t0 = 1'b0; vco_tick = 1'b1;
    wr_ratio(wr);
    wait_fall(1'b1, n);
    wait_fall(1'b1, n);
    chk(n == exp, req, n, exp);
  endtask

  task automatic t_midperiod_write();
    int n;
    t1 = 1'b1; t0 = 1'b0; vco_tick = 1'b1;
    wr_ratio(256);
    wait_fall(1'b1, n);
    wait_fall(1'b1, n);
    repeat (8) @(negedge clk);
    wr_ratio(300);
    wait_fall(1'b1, n);
    chk(n + 10 == 256, "R3 period in progress keeps old ratio", n + 10, 256);
    wait_fall(1'b1, n);
    chk(n == 300, "R3 new ratio from next wrap", n, 300);
  endtask

  task automatic t_ref_period();
    int n;
    t1 = 1'b1; t0 = 1'b0; xtal_tick = 1'b1;
    chk(tdrv == 1'b1, "R10 test_drive in mode 10", tdrv, 1);
    wait_fall(1'b0, n);
    wait_fall(1'b0, n);
    chk(n == 64, "R4 reference period", n, 64);
    xtal_tick = 1'b0;
  endtask

  // lead > 0: vco side falls first; lead < 0: ref side first
  task automatic t_ext(input int lead, input string req);
    int ups = 0, dns = 0, mag;
    mag = (lead < 0) ? -lead : lead;
    t1 = 1'b1; t0 = 1'b1; vco_tick = 1'b0; xtal_tick = 1'b0;
    ext_vco = 1'b1; ext_ref = 1'b1;
    do_reset();
    repeat (5) @(negedge clk);
    fork
      begin
        if (lead >= 0) ext_vco = 1'b0; else ext_ref = 1'b0;
        repeat (mag) @(negedge clk);
        ext_vco = 1'b0; ext_ref = 1'b0;
      end
      begin
        for (int i = 0; i < mag + 12; i++) begin
          @(negedge clk);
          if (up) ups++;
          if (dn) dns++;
        end
      end
    join
    chk(ups == ((lead > 0) ? mag : 0), {req, " up width"}, ups, (lead > 0) ? mag : 0);
    chk(dns == ((lead < 0) ? mag : 0), {req, " dn width"}, dns, (lead < 0) ? mag : 0);
    ext_vco = 1'b1; ext_ref = 1'b1;
  endtask

  task automatic t_ext_ignores_dividers();
    int act = 0;
    t1 = 1'b1; t0 = 1'b1; ext_vco = 1'b1; ext_ref = 1'b1;
    do_reset();
    vco_tick = 1'b1; xtal_tick = 1'b1;
    repeat (700) begin
      @(negedge clk);
      if (up || dn) act++;
    end
    chk(act == 0, "R11 dividers have no effect in mode 11", act, 0);
    vco_tick = 1'b0; xtal_tick = 1'b0;
  endtask

  // xtal tick once every xdiv cycles, vco tick every cycle, ratio 256
  task automatic run_loop(input bit m1, input bit m0, input int xdiv,
                          output int ups, output int dns, output int badhiz,
                          output int both, output int portact);
    ups = 0; dns = 0; badhiz = 0; both = 0; portact = 0;
    t1 = m1; t0 = m0;
    do_reset();
    vco_tick = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (up) ups++;
      if (dn) dns++;
      if (up && dn) both++;
      if (p1 || p0 || tdrv) portact++;
      if (m0 && !m1) begin
        if (!hiz) badhiz++;
      end else if (hiz != !(up || dn)) badhiz++;
      xtal_tick = ((i % xdiv) == 0);
    end
    vco_tick = 1'b0; xtal_tick = 1'b0;
  endtask

  task automatic t_loop_patterns();
    int u, d, bh, b, pa;
    run_loop(1'b0, 1'b0, 8, u, d, bh, b, pa);
    chk(u > 0, "R5 fast vco gives up pulses", u, 1);
    chk(d == 0, "R5 fast vco gives no dn", d, 0);
    chk(bh == 0, "R9 hiz tracks pulses", bh, 0);
    chk(pa == 0, "R10 ports quiet in mode 00", pa, 0);
    run_loop(1'b0, 1'b0, 1, u, d, bh, b, pa);
    chk(d > 0, "R6 slow vco gives dn pulses", d, 1);
    chk(u == 0, "R6 slow vco gives no up", u, 0);
    chk(b == 0, "R7 up and dn never together", b, 0);
    chk(bh == 0, "R9 hiz tracks pulses slow vco", bh, 0);
    run_loop(1'b0, 1'b1, 8, u, d, bh, b, pa);
    chk(u == 0 && d == 0, "R8 pump off holds pulses low", u + d, 0);
    chk(bh == 0, "R8 pump off holds hiz", bh, 0);
    chk(pa == 0, "R10 ports quiet in mode 01", pa, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_cur_sel();
    t_div_period(256, 256, "R1 minimum ratio");
    t_div_period(300, 300, "R1 ratio 300");
    t_div_period(1001, 1001, "R1 odd ratio 1001");
    t_div_period(32767, 32767, "R1 maximum ratio");
    do_reset();
    t_div_period(100, 256, "R2 ratio 100 floored");
    t_div_period(0, 256, "R2 ratio 0 floored");
    t_midperiod_write();
    vco_tick = 1'b0;
    t_ref_period();
    t_ext(5, "R5 vco leads by 5");
    t_ext(-17, "R6 ref leads by 17");
    t_ext(0, "R7 coincident edges");
    t_ext(1, "R11 external pins lead by 1");
    t_ext_ignores_dividers();
    t_loop_patterns();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule